// File: doc/BRIEF.md
# Spatial Noise Dither for Pixel Depth Reduction

This block lowers the precision of a three-channel 12-bit pixel stream to 6 or 8 significant bits per channel. Before the low bits are discarded, it adds pseudo-random noise to them, so that banding is spread into fine grain instead of visible contours. The noise comes from 28-bit linear feedback shift registers. All three channels can share one generator, or each channel can have its own generator with a different feedback polynomial.

Each generator takes a programmable seed. The seeds load at startup, and can optionally load again at the first pixel of every frame so that the grain is identical from frame to frame. An optional high-pass shaping replaces each noise sample with its difference from the previous sample. Configuration is applied with the unit disabled and then the unit is enabled. While the unit is disabled, or when an unsupported depth is chosen, pixels are simply truncated.

Top module: `spatial_dither`

## Requirements
- R1: Each output is registered one clock after its input. `out_valid` follows `in_valid` and `out_sof` follows `in_valid && in_sof` with one cycle of delay. The pixel outputs hold their value in cycles without a valid input. After reset, all outputs are zero.
- R2: Depth code `cfg_depth`=0 keeps the top 6 bits of each channel and clears the lower 6. Code 1 keeps the top 8 bits and clears the lower 4. Codes 2 and 3 are unsupported: dithering stays off and the top 8 bits are kept.
- R3: With `cfg_enable`=0, every output channel is the input channel with its dropped bits cleared. No noise is added.
- R4: With dithering active (enable=1 and depth code 0 or 1), the noise (6 bits at code 0, 4 bits at code 1) is added to the full 12-bit input. The sum saturates at 4095 and is then truncated as in R2.
- R5: A generator steps by shifting its 28-bit state left by one. The new bit 0 is state[27] XOR state[k-1] for polynomial x^28+x^k+1. Raw noise is the low noise-width bits of the state before the step. The generators step once per valid pixel while dithering is active, and hold otherwise.
- R6: With `cfg_per_channel`=0, all three channels take noise from one generator, seeded by `cfg_seed_r`, with k=3. The G and B seeds then have no effect.
- R7: With `cfg_per_channel`=1, R, G and B use their own seeds with k=3, 9 and 13 respectively.
- R8: While `cfg_enable`=0, each generator is held at its seed and the high-pass history is cleared. After enabling, the first valid pixel uses the seed state.
- R9: With `cfg_frame_reseed`=1, a valid pixel with `in_sof`=1 uses the seed state, and its step starts from the seed. With `cfg_frame_reseed`=0, `in_sof` has no effect on the noise.
- R10: With `cfg_highpass`=1, the noise is (raw minus the previous valid pixel's raw) modulo 2^width. The previous raw value is zero right after enabling. With `cfg_highpass`=0, the raw noise is used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Dither enable; change other settings only while low |
| cfg_depth | input | 2 | Target depth code (0: 6 bits, 1: 8 bits, 2/3: unsupported) |
| cfg_per_channel | input | 1 | 1 selects one generator per channel |
| cfg_frame_reseed | input | 1 | 1 reloads seeds at each frame start |
| cfg_highpass | input | 1 | 1 selects high-pass shaped noise |
| cfg_seed_r | input | 28 | Seed of the R (or shared) generator |
| cfg_seed_g | input | 28 | Seed of the G generator |
| cfg_seed_b | input | 28 | Seed of the B generator |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_r | output | 12 | Red output, dropped bits zero |
| out_g | output | 12 | Green output, dropped bits zero |
| out_b | output | 12 | Blue output, dropped bits zero |

## Verification
On every cycle, the assertions check the one-cycle valid and frame-start delay, the holding of outputs between pixels, and the cleared low bits. They also check that a disabled unit only truncates, and that dithering never drops a channel below its plain truncation. Only the bench scenarios can show the exact noise sequence: the polynomial per channel, shared versus separate generators, seed loading on enable and at frame start, saturation at full scale, and the high-pass difference. For these, the bench runs its own generator model over several pixel runs and compares the outputs.

// File: rtl/dither_pkg.sv
package dither_pkg;
   localparam int NUM_CH = 3;

   typedef enum logic [1:0] {
      DEPTH_6    = 2'd0,
      DEPTH_8    = 2'd1,
      DEPTH_10   = 2'd2,
      DEPTH_RSVD = 2'd3
   } depth_e;
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
   parameter int LFSR_W = 28,
   parameter int TAP    = 3,
   parameter int NW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              reseed,
   input  logic              advance,
   input  logic [LFSR_W-1:0] seed,
   output logic [NW-1:0]     noise_bits
);
   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] cur;
   logic [LFSR_W-1:0] nxt;

   assign cur        = reseed ? seed : state_q;
   assign nxt        = {cur[LFSR_W-2:0], cur[LFSR_W-1] ^ cur[TAP-1]};
   assign noise_bits = cur[NW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= '0;
      else if (load)    state_q <= seed;
      else if (advance) state_q <= nxt;
   end
endmodule

// File: rtl/dither_channel.sv
module dither_channel #(
   parameter int CH_W = 12,
   parameter int NW   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            clear,
   input  logic            hp_en,
   input  logic            valid,
   input  logic [NW-1:0]   mask,
   input  logic [CH_W-1:0] keep_mask,
   input  logic [NW-1:0]   raw_bits,
   input  logic [CH_W-1:0] pix_in,
   output logic [CH_W-1:0] pix_out
);
   logic [NW-1:0]   raw;
   logic [NW-1:0]   prev_q;
   logic [NW-1:0]   hp;
   logic [NW-1:0]   noise;
   logic [CH_W:0]   sum;
   logic [CH_W-1:0] sat;

   assign raw   = raw_bits & mask;
   assign hp    = (raw - prev_q) & mask;
   assign noise = active ? (hp_en ? hp : raw) : '0;
   assign sum   = {1'b0, pix_in} + {{(CH_W + 1 - NW){1'b0}}, noise};
   assign sat   = sum[CH_W] ? {CH_W{1'b1}} : sum[CH_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)                prev_q <= '0;
      else if (clear)            prev_q <= '0;
      else if (active && valid)  prev_q <= raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pix_out <= '0;
      else if (valid) pix_out <= sat & keep_mask;
   end
endmodule

// File: rtl/spatial_dither.sv
module spatial_dither #(
   parameter int CH_W   = 12,
   parameter int LFSR_W = 28,
   parameter int TAP_R  = 3,
   parameter int TAP_G  = 9,
   parameter int TAP_B  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_per_channel,
   input  logic              cfg_frame_reseed,
   input  logic              cfg_highpass,
   input  logic [LFSR_W-1:0] cfg_seed_r,
   input  logic [LFSR_W-1:0] cfg_seed_g,
   input  logic [LFSR_W-1:0] cfg_seed_b,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [CH_W-1:0]   in_r,
   input  logic [CH_W-1:0]   in_g,
   input  logic [CH_W-1:0]   in_b,
   output logic              out_valid,
   output logic              out_sof,
   output logic [CH_W-1:0]   out_r,
   output logic [CH_W-1:0]   out_g,
   output logic [CH_W-1:0]   out_b
);
   import dither_pkg::*;

   localparam int DROP_LO = CH_W - 6;
   localparam int DROP_HI = CH_W - 8;
   localparam int NW      = DROP_LO;

   if (CH_W < 9) begin : g_bad_width
      $error("spatial_dither: CH_W must be at least 9");
   end
   if (LFSR_W < NW || TAP_R >= LFSR_W || TAP_G >= LFSR_W || TAP_B >= LFSR_W) begin : g_bad_lfsr
      $error("spatial_dither: taps and noise width must fit in LFSR_W");
   end

   depth_e            depth;
   logic              narrow;
   logic              active;
   logic              advance;
   logic              reseed;
   logic [NW-1:0]     nmask;
   logic [CH_W-1:0]   keep_mask;
   logic [LFSR_W-1:0] seeds  [NUM_CH];
   logic [CH_W-1:0]   pix_in [NUM_CH];
   logic [CH_W-1:0]   pix_out[NUM_CH];
   logic [NW-1:0]     gen_bits[NUM_CH];

   assign depth     = depth_e'(cfg_depth);
   assign narrow    = (depth == DEPTH_6);
   assign active    = cfg_enable && (depth == DEPTH_6 || depth == DEPTH_8);
   assign advance   = active && in_valid;
   assign reseed    = cfg_frame_reseed && in_sof;
   assign nmask     = narrow ? {NW{1'b1}} : NW'((1 << DROP_HI) - 1);
   assign keep_mask = narrow ? ~CH_W'((1 << DROP_LO) - 1) : ~CH_W'((1 << DROP_HI) - 1);

   assign seeds[0]  = cfg_seed_r;
   assign seeds[1]  = cfg_seed_g;
   assign seeds[2]  = cfg_seed_b;
   assign pix_in[0] = in_r;
   assign pix_in[1] = in_g;
   assign pix_in[2] = in_b;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int TAP = (g == 0) ? TAP_R : (g == 1) ? TAP_G : TAP_B;
      logic [NW-1:0] src_bits;

      dither_lfsr #(.LFSR_W(LFSR_W), .TAP(TAP), .NW(NW)) u_gen (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (!cfg_enable),
         .reseed    (reseed),
         .advance   (advance),
         .seed      (seeds[g]),
         .noise_bits(gen_bits[g])
      );

      if (g == 0) begin : g_own
         assign src_bits = gen_bits[0];
      end else begin : g_sel
         assign src_bits = cfg_per_channel ? gen_bits[g] : gen_bits[0];
      end

      dither_channel #(.CH_W(CH_W), .NW(NW)) u_dp (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (active),
         .clear    (!cfg_enable),
         .hp_en    (cfg_highpass),
         .valid    (in_valid),
         .mask     (nmask),
         .keep_mask(keep_mask),
         .raw_bits (src_bits),
         .pix_in   (pix_in[g]),
         .pix_out  (pix_out[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid && in_sof;
      end
   end

   assign out_r = pix_out[0];
   assign out_g = pix_out[1];
   assign out_b = pix_out[2];
endmodule

// File: rtl/dither_checks.sv
module dither_checks #(
   parameter int CH_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_enable,
   input logic [1:0]      cfg_depth,
   input logic            in_valid,
   input logic            in_sof,
   input logic [CH_W-1:0] in_r,
   input logic [CH_W-1:0] in_g,
   input logic [CH_W-1:0] in_b,
   input logic            out_valid,
   input logic            out_sof,
   input logic [CH_W-1:0] out_r,
   input logic [CH_W-1:0] out_g,
   input logic [CH_W-1:0] out_b
);
   logic [CH_W-1:0] kmask;
   logic [CH_W-1:0] tr_r, tr_g, tr_b;

   assign kmask = (cfg_depth == 2'd0) ? ~CH_W'((1 << (CH_W - 6)) - 1)
                                      : ~CH_W'((1 << (CH_W - 8)) - 1);
   assign tr_r  = in_r & kmask;
   assign tr_g  = in_g & kmask;
   assign tr_b  = in_b & kmask;

   assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_sof_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> out_sof);
   assert_sof_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
   assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_r[CH_W-9:0] == '0 && out_g[CH_W-9:0] == '0 && out_b[CH_W-9:0] == '0));
   assert_plain_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_enable) |=>
         (out_r == $past(tr_r) && out_g == $past(tr_g) && out_b == $past(tr_b)));
   assert_no_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_r >= $past(tr_r) && out_g >= $past(tr_g) && out_b >= $past(tr_b)));
endmodule

bind spatial_dither dither_checks #(.CH_W(CH_W)) u_chk (.*);

// File: tb/sim_spatial_dither.sv
module sim_spatial_dither;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [1:0]  cfg_depth = 2'd0;
   logic        cfg_per_channel = 1'b0;
   logic        cfg_frame_reseed = 1'b0;
   logic        cfg_highpass = 1'b0;
   logic [27:0] cfg_seed_r = '0, cfg_seed_g = '0, cfg_seed_b = '0;
   logic        in_valid = 1'b0, in_sof = 1'b0;
   logic [11:0] in_r = '0, in_g = '0, in_b = '0;
   logic        out_valid, out_sof;
   logic [11:0] out_r, out_g, out_b;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   spatial_dither u0 (.*);

   // model state
   bit          m_en, m_shared, m_reseed, m_hp;
   int          m_depth;
   logic [27:0] m_seed[3];
   logic [27:0] ms[3];
   logic [5:0]  mp[3];
   int          tap[3] = '{3, 9, 13};

   function automatic logic [27:0] stp(logic [27:0] s, int t);
      return {s[26:0], s[27] ^ s[t-1]};
   endfunction

   task automatic check(bit ok, string tag, logic [37:0] act, logic [37:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setup(bit en, int depth, bit per_ch, bit reseed, bit hp,
                        logic [27:0] sr, logic [27:0] sg, logic [27:0] sb);
      @(negedge clk);
      cfg_enable = 1'b0;
      cfg_depth = 2'(depth); cfg_per_channel = per_ch;
      cfg_frame_reseed = reseed; cfg_highpass = hp;
      cfg_seed_r = sr; cfg_seed_g = sg; cfg_seed_b = sb;
      repeat (2) @(negedge clk);
      m_depth = depth; m_shared = !per_ch; m_reseed = reseed; m_hp = hp;
      m_seed[0] = sr; m_seed[1] = sg; m_seed[2] = sb;
      for (int k = 0; k < 3; k++) begin ms[k] = m_seed[k]; mp[k] = '0; end
      cfg_enable = en; m_en = en;
   endtask

   // drive one pixel, expect model result (or fixed result when use_fix)
   task automatic pix(logic [11:0] r, logic [11:0] g, logic [11:0] b, bit sof,
                      string tag, bit use_fix = 0, logic [35:0] fix = '0);
      logic [11:0] inp[3];
      logic [11:0] ex[3];
      logic [27:0] us[3];
      logic [5:0]  msk, raw, nz;
      logic [11:0] keep;
      int          sum;
      bit          act;
      inp[0] = r; inp[1] = g; inp[2] = b;
      @(negedge clk);
      in_r = r; in_g = g; in_b = b; in_valid = 1'b1; in_sof = sof;
      act  = m_en && (m_depth < 2);
      msk  = (m_depth == 0) ? 6'h3F : 6'h0F;
      keep = (m_depth == 0) ? 12'hFC0 : 12'hFF0;
      for (int k = 0; k < 3; k++) us[k] = (m_reseed && sof) ? m_seed[k] : ms[k];
      for (int c = 0; c < 3; c++) begin
         raw = us[m_shared ? 0 : c][5:0] & msk;
         nz  = m_hp ? ((raw - mp[c]) & msk) : raw;
         if (!act) nz = '0;
         sum = int'(inp[c]) + int'(nz);
         if (sum > 4095) sum = 4095;
         ex[c] = 12'(sum) & keep;
         if (act) mp[c] = raw;
      end
      if (act) for (int k = 0; k < 3; k++) ms[k] = stp(us[k], tap[k]);
      if (use_fix) begin ex[0] = fix[35:24]; ex[1] = fix[23:12]; ex[2] = fix[11:0]; end
      @(posedge clk); #5;
      check(out_valid && out_sof == sof && out_r == ex[0] && out_g == ex[1] && out_b == ex[2],
            tag, {out_valid, out_sof, out_r, out_g, out_b}, {1'b1, sof, ex[0], ex[1], ex[2]});
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
   endtask

   // table: en, depth, r, g, b, expected r, g, b  (dither off or unsupported depth)
   localparam logic [74:0] TABLE [6] = '{
      {1'b0, 2'd0, 12'hFFF, 12'h123, 12'hA5A, 12'hFC0, 12'h100, 12'hA40},
      {1'b0, 2'd1, 12'hFFF, 12'h123, 12'hA5A, 12'hFF0, 12'h120, 12'hA50},
      {1'b0, 2'd2, 12'hABC, 12'h00F, 12'h7F8, 12'hAB0, 12'h000, 12'h7F0},
      {1'b0, 2'd3, 12'h555, 12'hAAA, 12'h0F0, 12'h550, 12'hAA0, 12'h0F0},
      {1'b1, 2'd2, 12'hABC, 12'h00F, 12'h7F8, 12'hAB0, 12'h000, 12'h7F0},
      {1'b1, 2'd3, 12'hFFF, 12'h001, 12'h888, 12'hFF0, 12'h000, 12'h880}
   };

   initial begin
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [11:0] hr, hg, hb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!out_valid && !out_sof && out_r == 0 && out_g == 0 && out_b == 0, "R1 reset",
            {out_valid, out_sof, out_r, out_g, out_b}, '0);

      // R2 / R3 table of plain-truncation vectors
      foreach (TABLE[i]) begin
         setup(TABLE[i][74], int'(TABLE[i][73:72]), 1'b1, 1'b0, 1'b0, 28'h1, 28'h2, 28'h3);
         pix(TABLE[i][71:60], TABLE[i][59:48], TABLE[i][47:36], 1'b0,
             i < 4 ? "R3 R2 truncation" : "R2 unsupported depth", 1'b1, TABLE[i][35:0]);
      end

      // R1 hold during idle
      hr = out_r; hg = out_g; hb = out_b;
      @(posedge clk); #5;
      check(!out_valid && out_r == hr && out_g == hg && out_b == hb, "R1 hold",
            {out_valid, 1'b0, out_r, out_g, out_b}, {1'b0, 1'b0, hr, hg, hb});

      // R4 / R6 shared generator, depth 6, saturation at full scale
      setup(1'b1, 0, 1'b0, 1'b0, 1'b0, 28'h000003F, 28'h0ABCDEF, 28'h1234567);
      pix(12'hFFF, 12'hFFF, 12'hFFF, 1'b0, "R4 saturate", 1'b1, {12'hFC0, 12'hFC0, 12'hFC0});
      setup(1'b1, 0, 1'b0, 1'b0, 1'b0, 28'h000003F, 28'h0ABCDEF, 28'h1234567);
      pix(12'h7C1, 12'h7C0, 12'h000, 1'b0, "R4 carry", 1'b1, {12'h800, 12'h7C0, 12'h000});
      for (int i = 0; i < 10; i++)
         pix(12'(i * 397 + 5), 12'(i * 211 + 900), 12'(4095 - i * 97), 1'b0, "R6 shared");

      // R5 / R7 per-channel generators, depth 8
      setup(1'b1, 1, 1'b1, 1'b0, 1'b0, 28'h8F3A5C1, 28'h0C0FFEE, 28'h5A5A5A5);
      for (int i = 0; i < 40; i++)
         pix(12'(i * 103 + 17), 12'(i * 59 + 3), 12'(4000 - i * 31), 1'b0, "R7 R5 per-channel");

      // R9 frame reseed on
      setup(1'b1, 0, 1'b1, 1'b1, 1'b0, 28'h2468ACE, 28'h13579BD, 28'h0F0F0F1);
      for (int i = 0; i < 12; i++)
         pix(12'(i * 300 + 40), 12'(i * 150 + 70), 12'(i * 77 + 11), (i % 4) == 0, "R9 reseed");
      // R9 frame reseed off: sof has no effect
      setup(1'b1, 0, 1'b1, 1'b0, 1'b0, 28'h2468ACE, 28'h13579BD, 28'h0F0F0F1);
      for (int i = 0; i < 12; i++)
         pix(12'(i * 300 + 40), 12'(i * 150 + 70), 12'(i * 77 + 11), (i % 4) == 0, "R9 no reseed");

      // R8 disable then re-enable restarts from seed
      for (int i = 0; i < 5; i++)
         pix(12'(i * 500), 12'(i * 400), 12'(i * 300), 1'b0, "R8 run");
      setup(1'b1, 0, 1'b1, 1'b0, 1'b0, 28'h2468ACE, 28'h13579BD, 28'h0F0F0F1);
      for (int i = 0; i < 5; i++)
         pix(12'(i * 500), 12'(i * 400), 12'(i * 300), 1'b0, "R8 restart");

      // R10 high-pass shaped noise, both depths
      setup(1'b1, 0, 1'b1, 1'b0, 1'b1, 28'h7654321, 28'h1111111, 28'h2C3D4E5);
      for (int i = 0; i < 16; i++)
         pix(12'(i * 250 + 9), 12'(i * 130 + 44), 12'(4095 - i * 200), 1'b0, "R10 highpass");
      setup(1'b1, 1, 1'b0, 1'b1, 1'b1, 28'h7654321, 28'h1111111, 28'h2C3D4E5);
      for (int i = 0; i < 16; i++)
         pix(12'(i * 250 + 9), 12'(i * 130 + 44), 12'(4095 - i * 200), (i % 5) == 0,
             "R10 highpass shared");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule